// File: doc/BRIEF.md
# First Single-Bit Error Address Capture

This block sits next to a vector table protected by single-error-correct, double-error-detect coding. Each corrected read of the table shows up as an event: a valid strobe, a single-bit-error indication and the word index of the word that was read. The first event that reports a single-bit error sets a sticky flag and stores the word-aligned byte offset of that word (index times four, zero-extended to 32 bits) in an address register. Later errors are ignored until software clears the flag. The stored offset is meaningful only while the flag is set.

Software reaches the block through a small register port that is always readable. The port selects between a status word, which holds the flag in bit 0, and the 32-bit address word. Writes take effect only when the privileged-access input is high. Writing 1 to bit 0 of the status word clears the flag. The address word can also be written directly. The address register has no reset of any kind, so its contents survive every reset. The flag is cleared by reset.

A two-state controller sequences the block. `CAP_ARMED` means the flag is clear and the block is waiting. `CAP_LOCKED` means the flag is set and the offset is frozen. The transitions are:
- CAPTURE (ARMED to LOCKED): an error event arrives.
- RELEASE (LOCKED to ARMED): a privileged clear arrives with no error event.
- RECAPTURE (LOCKED to LOCKED, storing a new offset): a clear and an error event arrive in the same cycle.
- HOLD: any other cycle, in either state.

Top module: `sbe_addr_capture`

## Requirements
- R1: After reset `sbe_flag` is 0 and a read of the status word (`bus_sel`=0) returns 0.
- R2: When the flag is clear, a cycle with `evt_valid`=1 and `evt_sbe`=1 sets the flag on the next clock edge and stores `{evt_idx,2'b00}` zero-extended to 32 bits in the address register.
- R3: A cycle with `evt_valid`=0 or `evt_sbe`=0 neither sets the flag nor changes the address register.
- R4: While the flag is set, further error events leave the address register unchanged.
- R5: A privileged write (`bus_wr`=1, `bus_priv`=1, `bus_sel`=0) with `bus_wdata[0]`=1 clears the flag. With `bus_wdata[0]`=0 the flag is unchanged.
- R6: If a flag clear and an error event arrive in the same cycle, the new offset is captured and the flag stays set.
- R7: Any write with `bus_priv`=0 is ignored by both the flag and the address register.
- R8: A privileged write with `bus_sel`=1 stores `bus_wdata` in the address register. A capture in the same cycle takes precedence over the write.
- R9: Reset leaves the address register's contents unchanged.
- R10: Reads need no privilege. `bus_rdata` is `{31'b0, sbe_flag}` when `bus_sel`=0 and the address register when `bus_sel`=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (flag only) |
| evt_valid | input | 1 | Corrected-read event strobe |
| evt_sbe | input | 1 | Event reports a single-bit error |
| evt_idx | input | IDX_W | Word index of the read within the table |
| bus_sel | input | 1 | Register select: 0 status, 1 address |
| bus_wr | input | 1 | Write strobe |
| bus_priv | input | 1 | Privileged-access qualifier for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| sbe_flag | output | 1 | Sticky single-bit-error flag |
| sbe_addr | output | 32 | Captured word-aligned offset |

## Verification
The hardest case to reach from the ports is a cycle in the locked state where a privileged clear and an error event coincide, sometimes together with other writes. Purely independent random inputs seldom line this up. Directed sequences therefore force RECAPTURE and the capture-over-write collision explicitly. A long random phase then keeps error events and status writes dense, so that clears often land next to events. A reset pulse in the middle of the run, taken after a known capture, shows that the offset survives while the flag drops.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    localparam int DATA_W   = 32;
    localparam int FLAG_BIT = 0;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_ADDR   = 1'b1;

    typedef enum logic {
        CAP_ARMED  = 1'b0,
        CAP_LOCKED = 1'b1
    } cap_state_e;
endpackage

// File: rtl/sbe_ctrl_fsm.sv
module sbe_ctrl_fsm
    import sbe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag,
    output logic cap_en
);
    cap_state_e state_q;
    cap_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: CAPTURE, RELEASE, RECAPTURE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED: begin
                if (hit) begin
                    state_d = CAP_LOCKED;
                end
            end
            CAP_LOCKED: begin
                if (clr && !hit) begin
                    state_d = CAP_ARMED;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        flag   = 1'b0;
        cap_en = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                flag   = 1'b0;
                cap_en = hit;
            end
            CAP_LOCKED: begin
                flag   = 1'b1;
                cap_en = hit && clr;
            end
        endcase
    end
endmodule

// File: rtl/sbe_addr_reg.sv
module sbe_addr_reg
    import sbe_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] addr_q
);
    localparam int OFS_W = IDX_W + 2;
    localparam int PAD_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] cap_ofs;

    generate
        if (PAD_W > 0) begin : g_pad
            assign cap_ofs = {{PAD_W{1'b0}}, cap_idx, 2'b00};
        end else begin : g_nopad
            assign cap_ofs = {cap_idx[DATA_W-3:0], 2'b00};
        end
    endgenerate

    // deliberately without reset: contents persist across every reset
    always_ff @(posedge clk) begin
        if (cap_en) begin
            addr_q <= cap_ofs;
        end else if (wr_en) begin
            addr_q <= wr_data;
        end
    end
endmodule

// File: rtl/sbe_rd_mux.sv
module sbe_rd_mux
    import sbe_pkg::*;
(
    input  logic              sel,
    input  logic              flag,
    input  logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (sel == SEL_ADDR) begin
            rdata = addr;
        end else begin
            rdata[FLAG_BIT] = flag;
        end
    end
endmodule

// File: rtl/sbe_addr_capture.sv
module sbe_addr_capture
    import sbe_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_sbe,
    input  logic [IDX_W-1:0]  evt_idx,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sbe_flag,
    output logic [DATA_W-1:0] sbe_addr
);
    logic hit;
    logic priv_wr;
    logic clr;
    logic addr_wr;
    logic cap_en;

    assign hit     = evt_valid && evt_sbe;
    assign priv_wr = bus_wr && bus_priv;
    assign clr     = priv_wr && (bus_sel == SEL_STATUS) && bus_wdata[FLAG_BIT];
    assign addr_wr = priv_wr && (bus_sel == SEL_ADDR);

    sbe_ctrl_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (clr),
        .flag   (sbe_flag),
        .cap_en (cap_en)
    );

    sbe_addr_reg #(.IDX_W(IDX_W)) u_addr (
        .clk     (clk),
        .cap_en  (cap_en),
        .cap_idx (evt_idx),
        .wr_en   (addr_wr),
        .wr_data (bus_wdata),
        .addr_q  (sbe_addr)
    );

    sbe_rd_mux u_rd (
        .sel   (bus_sel),
        .flag  (sbe_flag),
        .addr  (sbe_addr),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/sbe_addr_capture_chk.sv
module sbe_addr_capture_chk
    import sbe_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_sbe,
    input logic [IDX_W-1:0]  evt_idx,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_priv,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sbe_flag,
    input logic [DATA_W-1:0] sbe_addr
);
    logic [DATA_W-1:0] exp_ofs;
    assign exp_ofs = DATA_W'({evt_idx, 2'b00});

    // R2
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_sbe && !sbe_flag) |=> (sbe_flag && sbe_addr == $past(exp_ofs)));

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && !(bus_wr && bus_priv)) |=> $stable(sbe_addr));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && bus_wr && bus_priv && bus_sel == SEL_STATUS && bus_wdata[FLAG_BIT]
         && !(evt_valid && evt_sbe)) |=> !sbe_flag);

    // R6
    recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && bus_wr && bus_priv && bus_sel == SEL_STATUS && bus_wdata[FLAG_BIT]
         && evt_valid && evt_sbe) |=> (sbe_flag && sbe_addr == $past(exp_ofs)));

    // R7
    user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag && bus_wr && !bus_priv) |=> sbe_flag);

    // R3
    no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sbe_flag && !(evt_valid && evt_sbe)) |=> !sbe_flag);

    // R9
    reset_keeps_addr_chk: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n) && $past(sbe_flag, 2)) |-> $stable(sbe_addr));
endmodule

bind sbe_addr_capture sbe_addr_capture_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_sbe   (evt_sbe),
    .evt_idx   (evt_idx),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_wdata (bus_wdata),
    .sbe_flag  (sbe_flag),
    .sbe_addr  (sbe_addr)
);

// File: tb/sbe_addr_capture_bench.sv
`timescale 1ns/1ps
module sbe_addr_capture_bench;
    localparam int IDX_W = 10;
    localparam int DW    = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            evt_valid;
    logic            evt_sbe;
    logic [IDX_W-1:0] evt_idx;
    logic            bus_sel;
    logic            bus_wr;
    logic            bus_priv;
    logic [DW-1:0]   bus_wdata;
    logic [DW-1:0]   bus_rdata;
    logic            sbe_flag;
    logic [DW-1:0]   sbe_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic          m_flag;
    logic [DW-1:0] m_addr;

    always #4 clk = ~clk;

    sbe_addr_capture #(.IDX_W(IDX_W)) u_sbe_addr_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_sbe   (evt_sbe),
        .evt_idx   (evt_idx),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sbe_flag  (sbe_flag),
        .sbe_addr  (sbe_addr)
    );

    function automatic logic [DW-1:0] ofs_of(input logic [IDX_W-1:0] idx);
        return DW'({idx, 2'b00});
    endfunction

    function automatic logic f_hit(input logic v, input logic s);
        return v && s;
    endfunction

    function automatic logic f_clr(input logic wr, input logic pr, input logic sel,
                                   input logic [DW-1:0] wd);
        return wr && pr && !sel && wd[0];
    endfunction

    function automatic logic f_next_flag(input logic flag, input logic hit, input logic clr);
        if (hit) return 1'b1;
        if (clr) return 1'b0;
        return flag;
    endfunction

    function automatic logic [DW-1:0] f_next_addr(input logic [DW-1:0] addr, input logic flag,
                                                  input logic hit, input logic clr,
                                                  input logic awr, input logic [DW-1:0] wd,
                                                  input logic [IDX_W-1:0] idx);
        if (hit && (!flag || clr)) return ofs_of(idx);
        if (awr) return wd;
        return addr;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_valid = 1'b0; evt_sbe = 1'b0; evt_idx = '0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0; bus_wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic event_cyc(input logic [IDX_W-1:0] idx);
        idle(); evt_valid = 1'b1; evt_sbe = 1'b1; evt_idx = idx;
        cyc(); idle();
    endtask

    task automatic write_cyc(input logic pr, input logic sel, input logic [DW-1:0] wd);
        idle(); bus_wr = 1'b1; bus_priv = pr; bus_sel = sel; bus_wdata = wd;
        cyc(); idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] keep;
        process::self().srandom(32'h5be1);
        idle();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1
        bus_sel = 1'b0; #1;
        chk(sbe_flag == 1'b0, "R1 flag after reset", DW'(sbe_flag), 0);
        chk(bus_rdata == 0, "R1 status read after reset", bus_rdata, 0);

        // R3: non-error event, then error bit without valid
        idle(); evt_valid = 1'b1; evt_sbe = 1'b0; evt_idx = 10'd5; cyc();
        idle(); evt_valid = 1'b0; evt_sbe = 1'b1; evt_idx = 10'd6; cyc(); idle();
        chk(sbe_flag == 1'b0, "R3 no capture", DW'(sbe_flag), 0);

        // R2
        event_cyc(10'h2A7);
        chk(sbe_flag == 1'b1, "R2 flag set", DW'(sbe_flag), 1);
        chk(sbe_addr == 32'h0000_0A9C, "R2 offset", sbe_addr, 32'h0000_0A9C);

        // R4
        event_cyc(10'd3);
        chk(sbe_addr == 32'h0000_0A9C, "R4 locked offset", sbe_addr, 32'h0000_0A9C);

        // R7
        write_cyc(1'b0, 1'b0, 32'h1);
        chk(sbe_flag == 1'b1, "R7 user clear ignored", DW'(sbe_flag), 1);
        write_cyc(1'b0, 1'b1, 32'hDEAD_BEEF);
        chk(sbe_addr == 32'h0000_0A9C, "R7 user addr write ignored", sbe_addr, 32'h0000_0A9C);

        // R10: unprivileged reads
        bus_sel = 1'b1; bus_priv = 1'b0; #1;
        chk(bus_rdata == 32'h0000_0A9C, "R10 addr read", bus_rdata, 32'h0000_0A9C);
        bus_sel = 1'b0; #1;
        chk(bus_rdata == 32'h1, "R10 status read", bus_rdata, 32'h1);
        idle();

        // R5
        write_cyc(1'b1, 1'b0, 32'hFFFF_FFFE);
        chk(sbe_flag == 1'b1, "R5 write 0 keeps flag", DW'(sbe_flag), 1);
        write_cyc(1'b1, 1'b0, 32'h1);
        chk(sbe_flag == 1'b0, "R5 write 1 clears", DW'(sbe_flag), 0);

        // R6
        event_cyc(10'd7);
        idle(); evt_valid = 1'b1; evt_sbe = 1'b1; evt_idx = 10'd9;
        bus_wr = 1'b1; bus_priv = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h1;
        cyc(); idle();
        chk(sbe_flag == 1'b1, "R6 flag stays", DW'(sbe_flag), 1);
        chk(sbe_addr == 32'h24, "R6 recaptured", sbe_addr, 32'h24);

        // R8
        write_cyc(1'b1, 1'b1, 32'h1234_5678);
        chk(sbe_addr == 32'h1234_5678, "R8 priv addr write", sbe_addr, 32'h1234_5678);
        write_cyc(1'b1, 1'b0, 32'h1);
        idle(); evt_valid = 1'b1; evt_sbe = 1'b1; evt_idx = 10'd4;
        bus_wr = 1'b1; bus_priv = 1'b1; bus_sel = 1'b1; bus_wdata = 32'hCAFE_0000;
        cyc(); idle();
        chk(sbe_addr == 32'h10, "R8 capture beats write", sbe_addr, 32'h10);
        chk(sbe_flag == 1'b1, "R8 flag", DW'(sbe_flag), 1);

        // R9
        keep = sbe_addr;
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
        chk(sbe_flag == 1'b0, "R9 flag reset", DW'(sbe_flag), 0);
        chk(sbe_addr == keep, "R9 addr kept", sbe_addr, keep);

        // random phase
        m_flag = sbe_flag;
        m_addr = sbe_addr;
        for (int i = 0; i < 4000; i++) begin
            logic h, c, aw;
            evt_valid = ($urandom_range(0, 1) == 1);
            evt_sbe   = ($urandom_range(0, 9) < 4);
            evt_idx   = IDX_W'($urandom);
            bus_wr    = ($urandom_range(0, 9) < 3);
            bus_priv  = ($urandom_range(0, 1) == 1);
            bus_sel   = ($urandom_range(0, 2) == 0);
            bus_wdata = $urandom;
            #1;
            chk(bus_rdata == (bus_sel ? m_addr : DW'(m_flag)), "R10 random read",
                bus_rdata, bus_sel ? m_addr : DW'(m_flag));
            h  = f_hit(evt_valid, evt_sbe);
            c  = f_clr(bus_wr, bus_priv, bus_sel, bus_wdata);
            aw = bus_wr && bus_priv && bus_sel;
            m_addr = f_next_addr(m_addr, m_flag, h, c, aw, bus_wdata, evt_idx);
            m_flag = f_next_flag(m_flag, h, c);
            @(posedge clk); #1;
            chk(sbe_flag == m_flag, "R2/R5/R6 random flag", DW'(sbe_flag), DW'(m_flag));
            chk(sbe_addr == m_addr, "R4/R8 random addr", sbe_addr, m_addr);
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule